// File: doc/BRIEF.md
# Wide Input Sampler and Word Serializer

This block takes periodic snapshots of a 96-bit parallel digital input bus and delivers each snapshot to a 32-bit streaming FIFO as three consecutive words. The FIFO write port accepts one word per clock. A small phase counter therefore time-multiplexes the work: one slot captures the whole bus into a holding register, and the following slots present the three words one after another. The default schedule has four slots, so it takes one snapshot every four clocks and writes three words in every four clocks. A build-time option selects a three-slot schedule instead. In that schedule the capture and the first word share a slot, which gives one snapshot every three clocks and a word on every clock.

The receiving side splits the stream by word position modulo three. If the FIFO reports full while a word is offered, that word and the rest of its snapshot are discarded, and a sticky overflow flag is raised. The stream then restarts on a first word. A synchronous FIFO model with a parameterized depth sits beside the block, so the pair can be exercised without any external consumer.

Top module: `wide_sampler_serializer`

## Requirements
- R1: Each snapshot is presented as three words on consecutive cycles: first bits [31:0], then [63:32], then [95:64].
- R2: In the default schedule, the capture happens at the clock edge that ends slot 0. `wr_valid` is high during slots 1, 2 and 3 and low during slot 0, which repeats every four clocks.
- R3: `overflow` is set at the clock edge that ends any cycle in which `wr_valid` and `fifo_full` are both high. After that it stays high until reset.
- R4: When a word is offered while `fifo_full` is high, that word and the remaining words of the same snapshot are withheld, with `wr_valid` low. The next snapshot starts again at its first word.
- R5: The second and third words come from the value sampled at the capture edge, even if `sample_in` changes afterwards.
- R6: With `THREE_PHASE` set, the capture edge also loads the first word. `wr_valid` is then high on every cycle once the first capture has happened. That capture is the third edge after reset is released.
- R7: A synchronous active-high `rst` returns the phase to 0 and clears the holding register, `wr_valid`, `wr_data` and `overflow`. In the default schedule the first capture happens at the first edge after release.
- R8: The FIFO model stores at most one word per clock and ignores writes while full. It returns words first in, first out, and read data and its valid flag appear one cycle after a read request. Its depth defaults to ten times the consumer's read block of 16 words, which is 160 words.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_in | input | 96 | Raw parallel input bus |
| fifo_full | input | 1 | Downstream FIFO cannot take a word this cycle |
| wr_valid | output | 1 | A word is offered on `wr_data` this cycle |
| wr_data | output | 32 | Word offered to the FIFO |
| overflow | output | 1 | Sticky flag: a word was offered while the FIFO was full |

## Verification
The assertions assume that `fifo_full` is a level that is only sampled at clock edges. They do not assume it is related to `wr_valid` in any way, so blocked words may land on any word position. They also assume that `rst` is held for at least one edge before its effects are checked. The stimulus changes `sample_in`, `fifo_full` and `rst` only on falling edges. It raises the forced-full condition for exactly one offered word, at the first word or at a middle word, and it also lets the real FIFO model fill up on its own. This exercises both the sticky flag and the restart on a first word without any assumption about when the consumer drains.

// File: rtl/sampler_pkg.sv
package sampler_pkg;
  localparam int unsigned DEF_WORD_W = 32;
  localparam int unsigned SNAP_WORDS = 3;
  localparam int unsigned PHASE_W    = 2;
  localparam int unsigned DEF_BLOCK  = 16;
  localparam int unsigned DEPTH_MULT = 10;
  typedef logic [PHASE_W-1:0] phase_t;
endpackage

// File: rtl/phase_sequencer.sv
module phase_sequencer
  import sampler_pkg::*;
#(
  parameter bit THREE_PHASE = 1'b0
) (
  input  logic   clk,
  input  logic   rst,
  output phase_t phase,
  output logic   capture,
  output logic   next_in_word,
  output phase_t next_idx
);
  localparam phase_t LAST   = THREE_PHASE ? 2'd2 : 2'd3;
  localparam phase_t OFFSET = THREE_PHASE ? 2'd0 : 2'd1;

  phase_t phase_q, nxt;

  assign nxt = (phase_q == LAST) ? 2'd0 : phase_q + 2'd1;

  always_ff @(posedge clk) begin
    if (rst) phase_q <= 2'd0;
    else     phase_q <= nxt;
  end

  assign phase        = phase_q;
  assign capture      = (nxt == OFFSET);
  assign next_idx     = nxt - OFFSET;
  assign next_in_word = THREE_PHASE || (nxt != 2'd0);
endmodule

// File: rtl/snapshot_hold.sv
module snapshot_hold #(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned N_WORDS = 3
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        capture,
  input  logic [WORD_W*N_WORDS-1:0]   din,
  output logic [WORD_W*N_WORDS-1:0]   held
);
  for (genvar g = 0; g < N_WORDS; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst)          held[g*WORD_W +: WORD_W] <= '0;
      else if (capture) held[g*WORD_W +: WORD_W] <= din[g*WORD_W +: WORD_W];
    end
  end
endmodule

// File: rtl/word_emitter.sv
module word_emitter
  import sampler_pkg::*;
#(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned N_WORDS = 3
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      capture,
  input  logic                      next_in_word,
  input  phase_t                    next_idx,
  input  logic [WORD_W-1:0]         first_word,
  input  logic [WORD_W*N_WORDS-1:0] held,
  input  logic                      fifo_full,
  output logic                      wr_valid,
  output logic [WORD_W-1:0]         wr_data,
  output logic                      overflow
);
  logic [WORD_W-1:0] lane [N_WORDS];
  logic [WORD_W-1:0] held_word;

  for (genvar g = 0; g < N_WORDS; g++) begin : g_lane
    assign lane[g] = held[g*WORD_W +: WORD_W];
  end

  always_comb begin
    held_word = '0;
    for (int i = 0; i < N_WORDS; i++)
      if (next_idx == PHASE_W'(i)) held_word = lane[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_valid <= 1'b0;
      wr_data  <= '0;
      overflow <= 1'b0;
    end else begin
      overflow <= overflow | (wr_valid & fifo_full);
      if (capture) begin
        wr_valid <= 1'b1;
        wr_data  <= first_word;
      end else if (next_in_word) begin
        wr_valid <= wr_valid & ~fifo_full;
        wr_data  <= held_word;
      end else begin
        wr_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/word_fifo.sv
module word_fifo
  import sampler_pkg::*;
#(
  parameter int unsigned WIDTH      = DEF_WORD_W,
  parameter int unsigned READ_BLOCK = DEF_BLOCK,
  parameter int unsigned DEPTH      = DEPTH_MULT * READ_BLOCK
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  output logic             full,
  input  logic             rd_en,
  output logic [WIDTH-1:0] rd_data,
  output logic             rd_valid,
  output logic             empty
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST_PTR = AW'(DEPTH - 1);
  localparam logic [CW-1:0] CAP      = CW'(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wp, rp;
  logic [CW-1:0]    cnt;
  logic             do_wr, do_rd;

  assign full  = (cnt == CAP);
  assign empty = (cnt == '0);
  assign do_wr = wr_en & ~full;
  assign do_rd = rd_en & ~empty;

  always_ff @(posedge clk) begin
    if (do_wr) mem[wp] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (do_rd) rd_data <= mem[rp];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp       <= '0;
      rp       <= '0;
      cnt      <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= do_rd;
      if (do_wr) wp <= (wp == LAST_PTR) ? '0 : wp + 1'b1;
      if (do_rd) rp <= (rp == LAST_PTR) ? '0 : rp + 1'b1;
      case ({do_wr, do_rd})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/wide_sampler_serializer.sv
module wide_sampler_serializer
  import sampler_pkg::*;
#(
  parameter int unsigned WORD_W      = DEF_WORD_W,
  parameter bit          THREE_PHASE = 1'b0
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [WORD_W*SNAP_WORDS-1:0] sample_in,
  input  logic                         fifo_full,
  output logic                         wr_valid,
  output logic [WORD_W-1:0]            wr_data,
  output logic                         overflow
);
  localparam int unsigned IN_W = WORD_W * SNAP_WORDS;

  phase_t          phase, next_idx;
  logic            capture, next_in_word;
  logic [IN_W-1:0] held;

  phase_sequencer #(.THREE_PHASE(THREE_PHASE)) u_seq (
    .clk(clk), .rst(rst), .phase(phase), .capture(capture),
    .next_in_word(next_in_word), .next_idx(next_idx)
  );

  snapshot_hold #(.WORD_W(WORD_W), .N_WORDS(SNAP_WORDS)) u_hold (
    .clk(clk), .rst(rst), .capture(capture), .din(sample_in), .held(held)
  );

  word_emitter #(.WORD_W(WORD_W), .N_WORDS(SNAP_WORDS)) u_emit (
    .clk(clk), .rst(rst), .capture(capture), .next_in_word(next_in_word),
    .next_idx(next_idx), .first_word(sample_in[WORD_W-1:0]), .held(held),
    .fifo_full(fifo_full), .wr_valid(wr_valid), .wr_data(wr_data),
    .overflow(overflow)
  );
endmodule

// File: rtl/sampler_checker.sv
module sampler_checker
  import sampler_pkg::*;
#(
  parameter bit THREE_PHASE = 1'b0
) (
  input logic   clk,
  input logic   rst,
  input logic   fifo_full,
  input logic   wr_valid,
  input logic   overflow,
  input phase_t phase
);
  localparam phase_t OFFSET = THREE_PHASE ? 2'd0 : 2'd1;
  phase_t widx;
  assign widx = phase - OFFSET;

  assert_ovf_sticky_R3: assert property (@(posedge clk) disable iff (rst)
    overflow |=> overflow);

  assert_ovf_set_R3: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && fifo_full) |=> overflow);

  assert_drop_rest_R4: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && fifo_full && widx != 2'd2) |=> !wr_valid);

  assert_reset_clear_R7: assert property (@(posedge clk)
    rst |=> (!wr_valid && !overflow && phase == 2'd0));

  if (THREE_PHASE) begin : g_p3
    assert_p3_stream_R6: assert property (@(posedge clk) disable iff (rst)
      (phase == 2'd2) |=> wr_valid);
    assert_p3_range_R6: assert property (@(posedge clk) disable iff (rst)
      phase != 2'd3);
  end else begin : g_p4
    assert_idle_slot_R2: assert property (@(posedge clk) disable iff (rst)
      (phase == 2'd0) |-> !wr_valid);
    assert_first_word_R1: assert property (@(posedge clk) disable iff (rst)
      $rose(wr_valid) |-> (phase == 2'd1));
  end
endmodule

bind wide_sampler_serializer sampler_checker #(.THREE_PHASE(THREE_PHASE)) u_chk (
  .clk(clk), .rst(rst), .fifo_full(fifo_full), .wr_valid(wr_valid),
  .overflow(overflow), .phase(phase)
);

// File: tb/wide_sampler_serializer_tb.sv
module wide_sampler_serializer_tb;
  localparam int unsigned NV = 6;
  // each entry: {stimulus snapshot, expected word0, word1, word2}
  localparam logic [191:0] TBL [NV] = '{
    {96'h00000003_00000002_00000001, 32'h00000001, 32'h00000002, 32'h00000003},
    {96'hFFFFFFFF_FFFFFFFF_FFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF},
    {96'h00000000_00000000_00000000, 32'h00000000, 32'h00000000, 32'h00000000},
    {96'hA5A5A5A5_5A5A5A5A_C3C3C3C3, 32'hC3C3C3C3, 32'h5A5A5A5A, 32'hA5A5A5A5},
    {96'h80000000_00000001_80000000, 32'h80000000, 32'h00000001, 32'h80000000},
    {96'h01234567_89ABCDEF_FEDCBA98, 32'hFEDCBA98, 32'h89ABCDEF, 32'h01234567}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [95:0] din = '0;
  logic        force_full = 1'b0;
  logic        wr_valid, overflow, wr_valid3, overflow3;
  logic [31:0] wr_data, wr_data3, rd_data;
  logic        fifo_full, fifo_empty, rd_valid;
  logic        rd_en = 1'b0;
  logic        dut_full;
  logic        p3_full = 1'b0;
  int          checks = 0;
  int          errors = 0;

  always #10 clk = ~clk;

  assign dut_full = fifo_full | force_full;

  wide_sampler_serializer u_dut (
    .clk(clk), .rst(rst), .sample_in(din), .fifo_full(dut_full),
    .wr_valid(wr_valid), .wr_data(wr_data), .overflow(overflow)
  );

  wide_sampler_serializer #(.THREE_PHASE(1'b1)) u_dut_p3 (
    .clk(clk), .rst(rst), .sample_in(din), .fifo_full(p3_full),
    .wr_valid(wr_valid3), .wr_data(wr_data3), .overflow(overflow3)
  );

  word_fifo #(.WIDTH(32), .READ_BLOCK(16)) u_fifo (
    .clk(clk), .rst(rst), .wr_en(wr_valid & ~dut_full), .wr_data(wr_data),
    .full(fifo_full), .rd_en(rd_en), .rd_data(rd_data), .rd_valid(rd_valid),
    .empty(fifo_empty)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic expect_word(input string req, input logic [31:0] exp);
    check(wr_valid === 1'b1 && wr_data === exp, req, {31'd0, wr_valid, wr_data},
          {32'd1, exp});
  endtask

  task automatic resync(input logic [95:0] first);
    rst = 1'b1;
    force_full = 1'b0;
    rd_en = 1'b0;
    repeat (2) @(negedge clk);
    check(!wr_valid && !overflow && wr_data == 32'd0, "R7 reset clears",
          {62'd0, wr_valid, overflow}, 64'd0);
    rst = 1'b0;
    din = first;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!wr_valid && !overflow && wr_data == 32'd0 && fifo_empty,
          "R7 reset state", {61'd0, wr_valid, overflow, fifo_empty}, 64'd1);
    rst = 1'b0;
    din = TBL[0][191:96];

    // table walk: R1 order, R2 slot pattern, R5 hold after input change
    for (int i = 0; i < NV; i++) begin
      din = TBL[i][191:96];
      @(negedge clk);
      expect_word("R1 word0", TBL[i][95:64]);
      din = ~TBL[i][191:96];
      @(negedge clk);
      expect_word("R5 word1 from held", TBL[i][63:32]);
      @(negedge clk);
      expect_word("R1 word2", TBL[i][31:0]);
      @(negedge clk);
      check(!wr_valid, "R2 idle slot", {63'd0, wr_valid}, 64'd0);
    end

    // FIFO readback in order (R8), no overflow so far (R3)
    rd_en = 1'b1;
    for (int i = 0; i < NV * 3; i++) begin
      @(negedge clk);
      check(rd_valid && rd_data == TBL[i/3][95 - 32*(i%3) -: 32], "R8 fifo order",
            {31'd0, rd_valid, rd_data}, {32'd1, TBL[i/3][95 - 32*(i%3) -: 32]});
    end
    rd_en = 1'b0;
    check(!overflow, "R3 no overflow without full", {63'd0, overflow}, 64'd0);

    // block first word (R3, R4)
    resync(96'h33333333_22222222_11111111);
    @(negedge clk);
    expect_word("R4 word0 offered", 32'h11111111);
    force_full = 1'b1;
    @(negedge clk);
    force_full = 1'b0;
    check(!wr_valid && overflow, "R4 rest dropped / R3 set",
          {62'd0, wr_valid, overflow}, 64'd1);
    @(negedge clk);
    check(!wr_valid, "R4 word2 dropped", {63'd0, wr_valid}, 64'd0);
    @(negedge clk);
    din = 96'hCCCCCCCC_BBBBBBBB_AAAAAAAA;
    @(negedge clk);
    expect_word("R4 restart word0", 32'hAAAAAAAA);
    @(negedge clk);
    expect_word("R4 restart word1", 32'hBBBBBBBB);
    @(negedge clk);
    expect_word("R4 restart word2", 32'hCCCCCCCC);
    check(overflow, "R3 sticky", {63'd0, overflow}, 64'd1);
    @(negedge clk);
    rd_en = 1'b1;
    @(negedge clk);
    check(rd_valid && rd_data == 32'hAAAAAAAA, "R4 fifo holds no partial",
          {31'd0, rd_valid, rd_data}, {32'd1, 32'hAAAAAAAA});
    rd_en = 1'b0;

    // block middle word (R4)
    resync(96'h66666666_55555555_44444444);
    @(negedge clk);
    expect_word("R4 mid word0", 32'h44444444);
    @(negedge clk);
    expect_word("R4 mid word1 offered", 32'h55555555);
    force_full = 1'b1;
    @(negedge clk);
    force_full = 1'b0;
    check(!wr_valid && overflow, "R4 word2 withheld",
          {62'd0, wr_valid, overflow}, 64'd1);
    @(negedge clk);
    check(!wr_valid, "R2 idle after drop", {63'd0, wr_valid}, 64'd0);

    // real FIFO fill (R8, R3)
    resync(96'h99999999_88888888_77777777);
    repeat (240) @(negedge clk);
    check(fifo_full && overflow, "R8 fifo fills at depth / R3",
          {62'd0, fifo_full, overflow}, 64'd3);
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    check(rd_valid && rd_data == 32'h77777777, "R8 oldest word first",
          {31'd0, rd_valid, rd_data}, {32'd1, 32'h77777777});

    // three-slot schedule (R6)
    resync(96'h0000000C_0000000B_0000000A);
    @(negedge clk);
    check(!wr_valid3, "R6 no word before capture", {63'd0, wr_valid3}, 64'd0);
    @(negedge clk);
    check(!wr_valid3, "R6 no word before capture", {63'd0, wr_valid3}, 64'd0);
    @(negedge clk);
    check(wr_valid3 && wr_data3 == 32'h0000000A, "R6 capture with word0",
          {31'd0, wr_valid3, wr_data3}, {32'd1, 32'h0000000A});
    @(negedge clk);
    check(wr_valid3 && wr_data3 == 32'h0000000B, "R6 word1",
          {31'd0, wr_valid3, wr_data3}, {32'd1, 32'h0000000B});
    @(negedge clk);
    check(wr_valid3 && wr_data3 == 32'h0000000C, "R6 word2",
          {31'd0, wr_valid3, wr_data3}, {32'd1, 32'h0000000C});
    din = 96'h0000000F_0000000E_0000000D;
    @(negedge clk);
    check(wr_valid3 && wr_data3 == 32'h0000000D, "R6 back-to-back word0",
          {31'd0, wr_valid3, wr_data3}, {32'd1, 32'h0000000D});
    din = '0;
    @(negedge clk);
    check(wr_valid3 && wr_data3 == 32'h0000000E, "R6 R5 held word1",
          {31'd0, wr_valid3, wr_data3}, {32'd1, 32'h0000000E});

    // reset mid-snapshot (R7)
    rst = 1'b1;
    @(negedge clk);
    check(!wr_valid && !wr_valid3 && !overflow, "R7 mid-stream reset",
          {61'd0, wr_valid, wr_valid3, overflow}, 64'd0);
    rst = 1'b0;
    din = 96'h00000000_00000000_12345678;
    @(negedge clk);
    expect_word("R7 capture at first edge", 32'h12345678);

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule